// File: doc/BRIEF.md
# Dual-Block Strided DMA Address Generator

This block produces the byte address sequence for one DMA channel. Each of two memory regions is described by a first address, a last address, an element size (1, 2 or 4 bytes) and an element-count stride. A start pulse captures the whole configuration and places the first address of region 1 on the output. After that, every cycle with the advance strobe high moves the address forward by one step. The step is the element size multiplied by the stride.

When the address reaches the last address of the active region, the next advance wraps it. In single-region mode the address returns to the first address of region 1. In dual-region mode it goes to the first address of the other region, so the channel alternates between the two. A one-cycle end pulse marks each wrap, and a flag shows which region is active. The surrounding channel logic consumes the address and drives the advance strobe on each accepted transfer.

Top module: `dma_block_addr_gen`

## Requirements
- R1: While reset is held and after it is released, `addr_o` is 0, `blk2_o` is 0 and `blk_end_o` is 0 until the first start.
- R2: The cycle after `start_i` is high, `addr_o` equals `b1_top_i` as it was at start, and `blk2_o` is 0.
- R3: The step equals the element size times the stride, in bytes. The size codes are: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, and 3 is treated as 4 bytes.
- R4: A stride of 0 is treated as 1. A stride of 1 gives consecutive elements, so the step equals the element size.
- R5: With `dual_i` = 0 at start, an advance from region 1's last address gives region 1's first address, and `blk2_o` stays 0.
- R6: With `dual_i` = 1 at start, an advance from region 1's last address gives region 2's first address, and `blk2_o` becomes 1.
- R7: While region 2 is active, an advance from its last address gives region 1's first address, and `blk2_o` becomes 0.
- R8: While region 2 is active, steps use region 2's own size and stride.
- R9: `blk_end_o` is 1 for exactly the cycle after each wrapping advance and is 0 otherwise.
- R10: `addr_o` holds when `adv_i` is low. Advances before the first start have no effect.
- R11: Configuration inputs are captured at start. Changes made during a run have no effect until the next start.
- R12: A start during a run restarts the sequence at region 1's first address. A start takes priority over an advance in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Capture configuration and begin at region 1 |
| adv_i | input | 1 | Advance one step |
| dual_i | input | 1 | 1 = alternate between two regions, 0 = region 1 only |
| b1_top_i | input | 32 | Region 1 first byte address |
| b1_bot_i | input | 32 | Region 1 last byte address |
| b1_size_i | input | 2 | Region 1 element size code |
| b1_stride_i | input | 16 | Region 1 stride in elements |
| b2_top_i | input | 32 | Region 2 first byte address |
| b2_bot_i | input | 32 | Region 2 last byte address |
| b2_size_i | input | 2 | Region 2 element size code |
| b2_stride_i | input | 16 | Region 2 stride in elements |
| addr_o | output | 32 | Current byte address |
| blk2_o | output | 1 | Region 2 is active |
| blk_end_o | output | 1 | A wrap happened on the last advance |

## Verification
The bench sweeps every size code and several strides, including 0, 1 and the maximum. A wrong shift, or stride 0 used without clamping, would give a step of 0 or a step with the wrong scale. It walks both regions through their wraps in both modes. A design that confused the two modes would leave region 1 or loop forever inside region 2. A design that used the active region's step for the wrong region would land off the expected addresses. It also changes the configuration in the middle of a run and asserts start together with advance. A design without capture would pick up the new stride, and one that gave the advance priority would start one step past the first address.

// File: rtl/dbag_pkg.sv
// Shared encodings for the dual-block address generator.
// Assumes the size code is two bits wide; the reserved code behaves as 4 bytes.
package dbag_pkg;

    typedef enum logic [1:0] {
        ESZ_1B  = 2'd0,
        ESZ_2B  = 2'd1,
        ESZ_4B  = 2'd2,
        ESZ_RSV = 2'd3
    } esz_e;

    // Map a size code to its log2 byte count.
    function automatic logic [1:0] esz_shift(input logic [1:0] code);
        case (esz_e'(code))
            ESZ_1B:  return 2'd0;
            ESZ_2B:  return 2'd1;
            default: return 2'd2;
        endcase
    endfunction

endpackage

// File: rtl/dbag_step_calc.sv
// Combinational byte step for one region: stride (clamped to at least 1)
// scaled by element size. Assumes STEP_W = STRIDE_W + 2 covers 4 x max stride.
module dbag_step_calc
    import dbag_pkg::*;
#(
    parameter int STRIDE_W = 16,
    parameter int STEP_W   = STRIDE_W + 2
) (
    input  logic [1:0]          size_i,
    input  logic [STRIDE_W-1:0] stride_i,
    output logic [STEP_W-1:0]   step_o
);

    logic [STRIDE_W-1:0] stride_eff;
    logic [STEP_W-1:0]   stride_ext;

    // Clamp the stride to its minimum of one element.
    always_comb begin
        stride_eff = (stride_i == '0) ? STRIDE_W'(1) : stride_i;
        stride_ext = STEP_W'(stride_eff);
    end

    // Scale by the element size with a shift.
    always_comb begin
        step_o = stride_ext << esz_shift(size_i);
    end

endmodule

// File: rtl/dbag_block_cfg.sv
// Holds one region's configuration, captured on start, with a precomputed
// step. Assumes the inputs are valid in the capture cycle.
module dbag_block_cfg #(
    parameter int ADDR_W   = 32,
    parameter int STRIDE_W = 16,
    parameter int STEP_W   = STRIDE_W + 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cap_i,
    input  logic [ADDR_W-1:0]   top_i,
    input  logic [ADDR_W-1:0]   bot_i,
    input  logic [1:0]          size_i,
    input  logic [STRIDE_W-1:0] stride_i,
    output logic [ADDR_W-1:0]   top_q,
    output logic [ADDR_W-1:0]   bot_q,
    output logic [STEP_W-1:0]   step_q
);

    logic [STEP_W-1:0] step_d;

    dbag_step_calc #(
        .STRIDE_W (STRIDE_W),
        .STEP_W   (STEP_W)
    ) u_step (
        .size_i   (size_i),
        .stride_i (stride_i),
        .step_o   (step_d)
    );

    // Capture the region settings on start and hold them for the run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            top_q  <= '0;
            bot_q  <= '0;
            step_q <= '0;
        end else if (cap_i) begin
            top_q  <= top_i;
            bot_q  <= bot_i;
            step_q <= step_d;
        end
    end

    // R4: a captured step is never zero, even for stride 0.
    a_r4_step_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        cap_i |=> (step_q != '0));

endmodule

// File: rtl/dbag_addr_seq.sv
// Address state machine: loads region 1's first address on start, steps on
// advance and wraps at the active region's last address. The wrap test is an
// exact compare, so each last address must lie on the step grid.
module dbag_addr_seq #(
    parameter int ADDR_W = 32,
    parameter int STEP_W = 18
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start_i,
    input  logic                       adv_i,
    input  logic                       dual_i,
    input  logic [ADDR_W-1:0]          start_top_i,
    input  logic [1:0][ADDR_W-1:0]     top_i,
    input  logic [1:0][ADDR_W-1:0]     bot_i,
    input  logic [1:0][STEP_W-1:0]     step_i,
    output logic [ADDR_W-1:0]          addr_o,
    output logic                       blk2_o,
    output logic                       blk_end_o
);

    localparam int PAD_W = ADDR_W - STEP_W;

    logic [ADDR_W-1:0] addr_q;
    logic              blk2_q;
    logic              end_q;
    logic              run_q;
    logic              dual_q;
    logic [ADDR_W-1:0] cur_bot;
    logic [ADDR_W-1:0] cur_step;
    logic              at_bot;

    // Select the active region's last address and step.
    always_comb begin
        cur_bot  = blk2_q ? bot_i[1] : bot_i[0];
        cur_step = {{PAD_W{1'b0}}, (blk2_q ? step_i[1] : step_i[0])};
        at_bot   = (addr_q == cur_bot);
    end

    // Advance, wrap or restart the address sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            blk2_q <= 1'b0;
            end_q  <= 1'b0;
            run_q  <= 1'b0;
            dual_q <= 1'b0;
        end else if (start_i) begin
            addr_q <= start_top_i;
            blk2_q <= 1'b0;
            end_q  <= 1'b0;
            run_q  <= 1'b1;
            dual_q <= dual_i;
        end else begin
            end_q <= 1'b0;
            if (run_q && adv_i) begin
                if (at_bot) begin
                    end_q <= 1'b1;
                    if (dual_q && !blk2_q) begin
                        blk2_q <= 1'b1;
                        addr_q <= top_i[1];
                    end else begin
                        blk2_q <= 1'b0;
                        addr_q <= top_i[0];
                    end
                end else begin
                    addr_q <= addr_q + cur_step;
                end
            end
        end
    end

    assign addr_o    = addr_q;
    assign blk2_o    = blk2_q;
    assign blk_end_o = end_q;

    // R2: start lands on region 1's first address with region 1 active.
    a_r2_start_top: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (addr_o == $past(start_top_i)) && !blk2_o);

    // R5: single-region runs never activate region 2.
    a_r5_single_stays: assert property (@(posedge clk) disable iff (!rst_n)
        !dual_q |-> !blk2_o);

    // R9: an end pulse always coincides with a first address of the new region.
    a_r9_end_at_top: assert property (@(posedge clk) disable iff (!rst_n)
        blk_end_o |-> (addr_o == (blk2_o ? top_i[1] : top_i[0])));

    // R10: without advance or start the address holds.
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv_i && !start_i) |=> $stable(addr_o));

endmodule

// File: rtl/dma_block_addr_gen.sv
// Top of the dual-block strided DMA address generator. One configuration
// holder per region (generated), feeding a shared address sequencer.
// Assumes ADDR_W exceeds STRIDE_W + 2.
module dma_block_addr_gen #(
    parameter int ADDR_W   = 32,
    parameter int STRIDE_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                adv_i,
    input  logic                dual_i,
    input  logic [ADDR_W-1:0]   b1_top_i,
    input  logic [ADDR_W-1:0]   b1_bot_i,
    input  logic [1:0]          b1_size_i,
    input  logic [STRIDE_W-1:0] b1_stride_i,
    input  logic [ADDR_W-1:0]   b2_top_i,
    input  logic [ADDR_W-1:0]   b2_bot_i,
    input  logic [1:0]          b2_size_i,
    input  logic [STRIDE_W-1:0] b2_stride_i,
    output logic [ADDR_W-1:0]   addr_o,
    output logic                blk2_o,
    output logic                blk_end_o
);

    localparam int NBLK   = 2;
    localparam int STEP_W = STRIDE_W + 2;

    logic [NBLK-1:0][ADDR_W-1:0]   in_top;
    logic [NBLK-1:0][ADDR_W-1:0]   in_bot;
    logic [NBLK-1:0][1:0]          in_size;
    logic [NBLK-1:0][STRIDE_W-1:0] in_stride;
    logic [NBLK-1:0][ADDR_W-1:0]   cfg_top;
    logic [NBLK-1:0][ADDR_W-1:0]   cfg_bot;
    logic [NBLK-1:0][STEP_W-1:0]   cfg_step;

    // Gather the per-region inputs into arrays.
    always_comb begin
        in_top    = {b2_top_i,    b1_top_i};
        in_bot    = {b2_bot_i,    b1_bot_i};
        in_size   = {b2_size_i,   b1_size_i};
        in_stride = {b2_stride_i, b1_stride_i};
    end

    for (genvar b = 0; b < NBLK; b++) begin : g_blk
        dbag_block_cfg #(
            .ADDR_W   (ADDR_W),
            .STRIDE_W (STRIDE_W),
            .STEP_W   (STEP_W)
        ) u_cfg (
            .clk      (clk),
            .rst_n    (rst_n),
            .cap_i    (start_i),
            .top_i    (in_top[b]),
            .bot_i    (in_bot[b]),
            .size_i   (in_size[b]),
            .stride_i (in_stride[b]),
            .top_q    (cfg_top[b]),
            .bot_q    (cfg_bot[b]),
            .step_q   (cfg_step[b])
        );
    end

    dbag_addr_seq #(
        .ADDR_W (ADDR_W),
        .STEP_W (STEP_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .adv_i       (adv_i),
        .dual_i      (dual_i),
        .start_top_i (b1_top_i),
        .top_i       (cfg_top),
        .bot_i       (cfg_bot),
        .step_i      (cfg_step),
        .addr_o      (addr_o),
        .blk2_o      (blk2_o),
        .blk_end_o   (blk_end_o)
    );

endmodule

// File: tb/dma_block_addr_gen_tb.sv
module dma_block_addr_gen_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        adv_i = 1'b0;
    logic        dual_i = 1'b0;
    logic [31:0] b1_top_i = '0, b1_bot_i = '0, b2_top_i = '0, b2_bot_i = '0;
    logic [1:0]  b1_size_i = '0, b2_size_i = '0;
    logic [15:0] b1_stride_i = '0, b2_stride_i = '0;
    logic [31:0] addr_o;
    logic        blk2_o, blk_end_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    dma_block_addr_gen u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .adv_i(adv_i), .dual_i(dual_i),
        .b1_top_i(b1_top_i), .b1_bot_i(b1_bot_i), .b1_size_i(b1_size_i), .b1_stride_i(b1_stride_i),
        .b2_top_i(b2_top_i), .b2_bot_i(b2_bot_i), .b2_size_i(b2_size_i), .b2_stride_i(b2_stride_i),
        .addr_o(addr_o), .blk2_o(blk2_o), .blk_end_o(blk_end_o)
    );

    // {size code, stride, expected step in bytes}: R3 and R4 sweep.
    localparam int NVEC = 10;
    localparam logic [37:0] VEC [NVEC] = '{
        {2'd0, 16'd1,     20'd1},
        {2'd1, 16'd1,     20'd2},
        {2'd2, 16'd1,     20'd4},
        {2'd3, 16'd1,     20'd4},
        {2'd0, 16'd0,     20'd1},
        {2'd2, 16'd0,     20'd4},
        {2'd1, 16'd5,     20'd10},
        {2'd2, 16'd3,     20'd12},
        {2'd0, 16'd7,     20'd7},
        {2'd2, 16'd65535, 20'd262140}
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_start();
        start_i = 1'b1;
        tick();
        start_i = 1'b0;
    endtask

    task automatic do_adv();
        adv_i = 1'b1;
        tick();
        adv_i = 1'b0;
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            finish_run();
        end
    end

    initial begin
        tick();
        tick();
        // R1: outputs during reset
        chk("R1 addr in reset", addr_o, 32'h0);
        chk("R1 blk2 in reset", {31'b0, blk2_o}, 32'h0);
        rst_n = 1'b1;
        tick();
        chk("R1 end after reset", {31'b0, blk_end_o}, 32'h0);

        // R10: advances before any start are ignored
        adv_i = 1'b1;
        repeat (3) tick();
        adv_i = 1'b0;
        chk("R10 adv before start", addr_o, 32'h0);

        // Vector table: R3 / R4 step sizes
        for (int i = 0; i < NVEC; i++) begin
            b1_size_i   = VEC[i][37:36];
            b1_stride_i = VEC[i][35:20];
            b1_top_i    = 32'h0000_0100;
            b1_bot_i    = 32'hFFFF_0000;
            dual_i      = 1'b0;
            do_start();
            chk("R2 start addr", addr_o, 32'h0000_0100);
            do_adv();
            chk("R3 R4 step", addr_o, 32'h0000_0100 + {12'b0, VEC[i][19:0]});
        end

        // R5 / R9: single-region wrap
        b1_top_i = 32'h1000; b1_bot_i = 32'h100C; b1_size_i = 2'd2; b1_stride_i = 16'd1;
        dual_i = 1'b0;
        do_start();
        do_adv(); do_adv(); do_adv();
        chk("R4 consecutive", addr_o, 32'h100C);
        chk("R9 no pulse before wrap", {31'b0, blk_end_o}, 32'h0);
        do_adv();
        chk("R5 single wrap addr", addr_o, 32'h1000);
        chk("R5 single wrap blk", {31'b0, blk2_o}, 32'h0);
        chk("R9 pulse on wrap", {31'b0, blk_end_o}, 32'h1);
        tick();
        chk("R9 pulse one cycle", {31'b0, blk_end_o}, 32'h0);
        // R10: hold without advance
        tick(); tick();
        chk("R10 hold", addr_o, 32'h1000);

        // R6 / R7 / R8 / R11: dual-region ping-pong
        b1_top_i = 32'h2000; b1_bot_i = 32'h2004; b1_size_i = 2'd1; b1_stride_i = 16'd2;
        b2_top_i = 32'h3000; b2_bot_i = 32'h3006; b2_size_i = 2'd0; b2_stride_i = 16'd3;
        dual_i = 1'b1;
        do_start();
        chk("R2 dual start", addr_o, 32'h2000);
        // R11: change config mid-run; must have no effect
        b1_stride_i = 16'd9; b2_stride_i = 16'd9; b2_top_i = 32'h5000; dual_i = 1'b0;
        do_adv();
        chk("R11 captured stride", addr_o, 32'h2004);
        do_adv();
        chk("R6 to region 2 addr", addr_o, 32'h3000);
        chk("R6 region 2 flag", {31'b0, blk2_o}, 32'h1);
        chk("R9 pulse dual", {31'b0, blk_end_o}, 32'h1);
        do_adv();
        chk("R8 region 2 step", addr_o, 32'h3003);
        chk("R9 no pulse mid", {31'b0, blk_end_o}, 32'h0);
        do_adv();
        chk("R8 region 2 step2", addr_o, 32'h3006);
        do_adv();
        chk("R7 back to region 1", addr_o, 32'h2000);
        chk("R7 region 1 flag", {31'b0, blk2_o}, 32'h0);
        chk("R9 pulse back", {31'b0, blk_end_o}, 32'h1);
        do_adv();
        chk("R11 region 1 step kept", addr_o, 32'h2004);

        // R12: start wins over advance, restart mid-run in region 2
        do_adv();
        chk("R6 region 2 again", {31'b0, blk2_o}, 32'h1);
        b1_top_i = 32'h4000; b1_bot_i = 32'h4010; b1_stride_i = 16'd1; b1_size_i = 2'd0;
        start_i = 1'b1; adv_i = 1'b1;
        tick();
        start_i = 1'b0; adv_i = 1'b0;
        chk("R12 restart addr", addr_o, 32'h4000);
        chk("R12 restart blk", {31'b0, blk2_o}, 32'h0);
        do_adv();
        chk("R12 step after restart", addr_o, 32'h4001);

        done = 1'b1;
        finish_run();
    end

endmodule